// File: doc/BRIEF.md
# Accumulator Store Rounding and Saturation Path

This block turns a 40-bit signed accumulator value into the 16-bit word that a store writes to memory. It first scales the value by a signed arithmetic shift, then optionally rounds it at the 16-bit boundary, and finally clamps it to the word range when saturate-on-store is enabled. The stored word is bits 31..16 of the processed value. The accumulator is only read here. It is never written back.

Rounding is either biased (add half, then truncate) or unbiased (round half to even), chosen by a mode bit. The clamp limits depend on a sign mode bit. In signed mode the word is clamped to the two's complement 16-bit range. In unsigned mode it is clamped to 0x0000..0xFFFF. A flag reports each result where the clamp changed the word. Results are registered and appear one cycle after a valid request.

Top module: `acc_store_path`

## Requirements
- R1: During and after synchronous reset, `res_valid`, `res_word` and `res_clamped` are all 0 until the first request has been processed.
- R2: A request presented with `req_valid`=1 at a rising edge produces `res_valid`=1 and its result after that edge. In a cycle with `req_valid`=0, `res_valid` goes to 0 and `res_word` holds its value.
- R3: The value is sign-extended and arithmetically shifted by `shift_amt` (two's complement, -16..+15). A positive amount shifts left and a negative amount shifts right. The word is then bits 31..16 of the result (truncation when rounding is off).
- R4: With `round_en`=1 and `round_even`=0, 0x8000 is added to the shifted value before the low 16 bits are dropped (biased rounding).
- R5: With `round_en`=1 and `round_even`=1, the result is the same as R4 except when bits 15..0 are exactly 0x8000. In that case the word is the one of the two neighbours whose bit 0 (bit 16 of the value) is 0.
- R6: With `round_en`=0, the low 16 bits are discarded without rounding, and `round_even` has no effect.
- R7: With `sat_en`=1 and `signed_mode`=1, a value above 0x7FFF_FFFF stores 0x7FFF and a value below -0x8000_0000 stores 0x8000.
- R8: With `sat_en`=1 and `signed_mode`=0, a negative value stores 0x0000 and a value above 0xFFFF_FFFF stores 0xFFFF.
- R9: With `sat_en`=0, the word is bits 31..16 as they are, wrapping on overflow, and `res_clamped` is 0.
- R10: `res_clamped` is 1 exactly when the stored word differs from bits 31..16 of the shifted and rounded value.
- R11: The operations apply in this order: shift, then rounding, then saturation. A value that rounding carries past the limit is therefore clamped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe for a store conversion |
| acc_in | input | 40 | Accumulator value, two's complement |
| shift_amt | input | 5 | Signed shift amount, -16..+15, negative = right |
| round_en | input | 1 | Enable rounding at the 16-bit boundary |
| round_even | input | 1 | 0 = biased rounding, 1 = round half to even |
| sat_en | input | 1 | Saturate on store |
| signed_mode | input | 1 | 1 = signed clamp limits, 0 = unsigned limits |
| res_valid | output | 1 | Result valid, one cycle after the request |
| res_word | output | 16 | Word to be stored |
| res_clamped | output | 1 | Saturation changed the stored word |

## Verification
The hardest case to reach from the ports is where two stages interact. One example is a value just below the positive limit that only rounding pushes over, so that the clamp must act on the rounded value. Another is an exact rounding tie, which must show a different outcome for odd and even high words. The stimulus builds these accumulator values directly, with low halves of exactly 0x8000 and high halves at 0x7FFF. It also builds cases where the clamp limit equals the raw word, so the flag must stay low even though the value is out of range. Random vectors across the full shift range run alongside these cases. Every result is compared against an independent integer model.

// File: rtl/store_pkg.sv
package store_pkg;
  typedef struct packed {
    logic rnd_en;
    logic rnd_even;
    logic sat_en;
    logic sgn;
  } store_ctrl_t;
endpackage

// File: rtl/store_shift.sv
module store_shift #(
  parameter int ACC_W = 40,
  parameter int SH_W  = 5,
  parameter int EXT_W = ACC_W + 2**(SH_W-1)
) (
  input  logic [ACC_W-1:0]        acc,
  input  logic signed [SH_W-1:0]  amt,
  output logic signed [EXT_W-1:0] shifted
);
  logic signed [EXT_W-1:0] ext;
  logic [SH_W-1:0]         mag;

  always_comb begin
    ext = {{(EXT_W-ACC_W){acc[ACC_W-1]}}, acc};
    mag = amt[SH_W-1] ? SH_W'(-amt) : SH_W'(amt);
    if (amt[SH_W-1]) shifted = ext >>> mag;
    else             shifted = ext <<< mag;
  end
endmodule

// File: rtl/store_round.sv
module store_round #(
  parameter int EXT_W  = 56,
  parameter int WORD_W = 16
) (
  input  logic signed [EXT_W-1:0] val,
  input  logic                    en,
  input  logic                    even,
  output logic signed [EXT_W-1:0] rounded
);
  localparam logic [EXT_W-1:0] HALF = EXT_W'(1) << (WORD_W-1);

  logic [EXT_W-1:0] sum;
  logic             tie;

  always_comb begin
    sum = val + HALF;
    tie = (val[WORD_W-1:0] == HALF[WORD_W-1:0]);
    if (en)
      rounded = {sum[EXT_W-1:WORD_W+1], sum[WORD_W] & ~(even & tie), {WORD_W{1'b0}}};
    else
      rounded = {val[EXT_W-1:WORD_W], {WORD_W{1'b0}}};
  end
endmodule

// File: rtl/store_clamp.sv
module store_clamp #(
  parameter int EXT_W  = 56,
  parameter int WORD_W = 16
) (
  input  logic signed [EXT_W-1:0] val,
  input  logic                    sat_en,
  input  logic                    sgn,
  output logic [WORD_W-1:0]       word,
  output logic                    clamped
);
  localparam int TOP = 2*WORD_W;

  logic [WORD_W-1:0] raw;
  logic [WORD_W-1:0] limit;
  logic              ovf;
  logic              neg;

  always_comb begin
    raw = val[TOP-1:WORD_W];
    neg = val[EXT_W-1];
    if (sgn) begin
      ovf   = !((&val[EXT_W-1:TOP-1]) || !(|val[EXT_W-1:TOP-1]));
      limit = neg ? {1'b1, {(WORD_W-1){1'b0}}} : {1'b0, {(WORD_W-1){1'b1}}};
    end else begin
      ovf   = |val[EXT_W-1:TOP];
      limit = neg ? {WORD_W{1'b0}} : {WORD_W{1'b1}};
    end
    word    = (sat_en && ovf) ? limit : raw;
    clamped = (word != raw);
  end
endmodule

// File: rtl/acc_store_path.sv
module acc_store_path #(
  parameter int ACC_W  = 40,
  parameter int WORD_W = 16,
  parameter int SH_W   = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic [ACC_W-1:0]       acc_in,
  input  logic signed [SH_W-1:0] shift_amt,
  input  logic                   round_en,
  input  logic                   round_even,
  input  logic                   sat_en,
  input  logic                   signed_mode,
  output logic                   res_valid,
  output logic [WORD_W-1:0]      res_word,
  output logic                   res_clamped
);
  import store_pkg::*;

  localparam int EXT_W = ACC_W + 2**(SH_W-1);

  store_ctrl_t             ctrl;
  logic signed [EXT_W-1:0] shifted;
  logic signed [EXT_W-1:0] rounded;
  logic [WORD_W-1:0]       word_d;
  logic                    clamp_d;

  assign ctrl = '{rnd_en: round_en, rnd_even: round_even, sat_en: sat_en, sgn: signed_mode};

  store_shift #(.ACC_W(ACC_W), .SH_W(SH_W), .EXT_W(EXT_W)) u_shift (
    .acc(acc_in), .amt(shift_amt), .shifted(shifted));

  store_round #(.EXT_W(EXT_W), .WORD_W(WORD_W)) u_round (
    .val(shifted), .en(ctrl.rnd_en), .even(ctrl.rnd_even), .rounded(rounded));

  store_clamp #(.EXT_W(EXT_W), .WORD_W(WORD_W)) u_clamp (
    .val(rounded), .sat_en(ctrl.sat_en), .sgn(ctrl.sgn), .word(word_d), .clamped(clamp_d));

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid   <= 1'b0;
      res_word    <= '0;
      res_clamped <= 1'b0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        res_word    <= word_d;
        res_clamped <= clamp_d;
      end
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_valid);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!res_valid && $stable(res_word)));

  assert_no_flag_unsat_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !sat_en) |=> !res_clamped);

  assert_flag_limit_R10: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_clamped) |->
      (res_word == {1'b0, {(WORD_W-1){1'b1}}} || res_word == {1'b1, {(WORD_W-1){1'b0}}} ||
       res_word == {WORD_W{1'b0}} || res_word == {WORD_W{1'b1}}));

  assert_signed_limit_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && sat_en && signed_mode) |=>
      (!res_clamped || res_word == {1'b0, {(WORD_W-1){1'b1}}} ||
       res_word == {1'b1, {(WORD_W-1){1'b0}}}));

  assert_unsigned_limit_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && sat_en && !signed_mode) |=>
      (!res_clamped || res_word == {WORD_W{1'b0}} || res_word == {WORD_W{1'b1}}));
endmodule

// File: tb/acc_store_path_test.sv
module acc_store_path_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [39:0] acc_in = '0;
  logic signed [4:0] shift_amt = '0;
  logic        round_en = 1'b0, round_even = 1'b0, sat_en = 1'b0, signed_mode = 1'b0;
  logic        res_valid;
  logic [15:0] res_word;
  logic        res_clamped;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  logic [16:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  acc_store_path uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .acc_in(acc_in), .shift_amt(shift_amt),
    .round_en(round_en), .round_even(round_even), .sat_en(sat_en), .signed_mode(signed_mode),
    .res_valid(res_valid), .res_word(res_word), .res_clamped(res_clamped));

  function automatic logic [16:0] ref_store(logic [39:0] a, int sh, bit re, bit rm, bit sat, bit sx);
    longint v, q, lo;
    logic [15:0] raw, res;
    v = {{24{a[39]}}, a};
    if (sh < 0) v = v >>> (-sh);
    else        v = v <<< sh;
    q  = v >>> 16;
    lo = v & 64'hFFFF;
    if (re && (lo > 32768 || (lo == 32768 && (!rm || q[0])))) q = q + 1;
    raw = q[15:0];
    res = raw;
    if (sat) begin
      if (sx) begin
        if (q > 32767)       res = 16'h7FFF;
        else if (q < -32768) res = 16'h8000;
      end else begin
        if (q < 0)           res = 16'h0000;
        else if (q > 65535)  res = 16'hFFFF;
      end
    end
    return {res != raw, res};
  endfunction

  task automatic send(input logic [39:0] a, input int sh, input bit re, input bit rm,
                      input bit sat, input bit sx, input string tag);
    @(negedge clk);
    req_valid = 1'b1; acc_in = a; shift_amt = 5'(sh);
    round_en = re; round_even = rm; sat_en = sat; signed_mode = sx;
    exp_q.push_back(ref_store(a, sh, re, rm, sat, sx));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (exp_q.size() == 0) begin
        miscompares++;
        $display("FAIL R2: unexpected result word=%h expected none", res_word);
      end else begin
        logic [16:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        vectors++;
        if ({res_clamped, res_word} != e) begin
          miscompares++;
          $display("FAIL %s: word=%h flag=%0b expected word=%h flag=%0b",
                   t, res_word, res_clamped, e[15:0], e[16]);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    vectors++;
    if (res_valid !== 1'b0 || res_word !== 16'h0 || res_clamped !== 1'b0) begin
      miscompares++;
      $display("FAIL R1: valid=%b word=%h flag=%b expected 0 0000 0", res_valid, res_word, res_clamped);
    end
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    vectors++;
    if (res_valid !== 1'b0 || res_word !== 16'h0) begin
      miscompares++;
      $display("FAIL R1: after reset valid=%b word=%h expected 0 0000", res_valid, res_word);
    end

    // R3 shift and truncation
    send(40'h00_1234_5678, 0, 0, 0, 0, 1, "R3");
    send(40'h00_1234_5678, 4, 0, 0, 0, 1, "R3");
    send(40'hFF_8000_0000, -16, 0, 0, 0, 1, "R3");
    send(40'h00_0000_ABCD, 15, 0, 0, 0, 1, "R3");
    send(40'h80_0000_0000, -1, 0, 0, 0, 1, "R3");
    // R4 biased rounding
    send(40'h00_0001_8000, 0, 1, 0, 0, 1, "R4");
    send(40'h00_0001_7FFF, 0, 1, 0, 0, 1, "R4");
    send(40'hFF_FFFE_8000, 0, 1, 0, 0, 1, "R4");
    // R5 round half to even
    send(40'h00_0001_8000, 0, 1, 1, 0, 1, "R5");
    send(40'h00_0002_8000, 0, 1, 1, 0, 1, "R5");
    send(40'h00_0002_8001, 0, 1, 1, 0, 1, "R5");
    send(40'hFF_FFFE_8000, 0, 1, 1, 0, 1, "R5");
    // R6 rounding off ignores the mode bit
    send(40'h00_0002_8000, 0, 0, 1, 0, 1, "R6");
    send(40'h00_0003_FFFF, 0, 0, 0, 0, 1, "R6");
    idle(2);
    // R7 signed clamp
    send(40'h00_8000_0000, 0, 0, 0, 1, 1, "R7");
    send(40'hFF_7FFF_FFFF, 0, 0, 0, 1, 1, "R7");
    send(40'h00_7FFF_FFFF, 0, 0, 0, 1, 1, "R7");
    send(40'hFF_8000_0000, 0, 0, 0, 1, 1, "R7");
    // R8 unsigned clamp
    send(40'hFF_FFFF_0000, 0, 0, 0, 1, 0, "R8");
    send(40'h01_0000_0000, 0, 0, 0, 1, 0, "R8");
    send(40'h00_FFFF_0000, 0, 0, 0, 1, 0, "R8");
    // R9 no saturation: wrap
    send(40'h00_8000_0000, 0, 0, 0, 0, 1, "R9");
    send(40'h01_2345_0000, 0, 0, 0, 0, 0, "R9");
    // R10 out of range but limit equals raw: flag stays low
    send(40'h01_7FFF_0000, 0, 0, 0, 1, 1, "R10");
    send(40'h7F_FFFF_0000, 0, 0, 0, 1, 0, "R10");
    // R11 ordering
    send(40'h00_7FFF_8000, 0, 1, 0, 1, 1, "R11");
    send(40'h00_7FFF_8000, 0, 1, 1, 1, 1, "R11");
    send(40'h00_0001_0000, 15, 0, 0, 1, 1, "R11");
    send(40'h00_FFFF_8000, 0, 1, 0, 1, 0, "R11");
    idle(1);
    // R2 hold check: word must not change across idle cycles
    begin
      logic [15:0] held;
      held = res_word;
      idle(2);
      vectors++;
      if (res_valid !== 1'b0 || res_word !== held) begin
        miscompares++;
        $display("FAIL R2: idle valid=%b word=%h expected 0 %h", res_valid, res_word, held);
      end
    end
    // mixed random vectors
    for (int i = 0; i < 60; i++) begin
      send({$urandom, $urandom} & 64'hFF_FFFF_FFFF, int'($urandom_range(0, 31)) - 16,
           1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "R3_R11 random");
      if (i % 7 == 0) idle(1);
    end
    idle(4);
    vectors++;
    if (exp_q.size() != 0) begin
      miscompares++;
      $display("FAIL R2: %0d results missing, expected 0", exp_q.size());
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule